// File: doc/BRIEF.md
# Thirty-Two Source Interrupt Controller

This block collects up to 32 interrupt request lines into a bank of sticky pending bits. It filters them through a per-source enable mask and signals the processor on one summary line. A request line that is high at a clock edge sets its pending bit. The bit then stays set after the line drops, so one-cycle pulses and held levels are both caught. Software acknowledges a source by writing a one to its pending bit. Masking a source hides it from the output without discarding its pending state.

The processor sees a gated view, which is the pending bits ANDed with the enable bits. Only the highest-numbered gated source is taken as the valid request, and its index is driven on a dedicated output. Access goes through a single-cycle register bus with a 32-bit data width. Writes take effect at the clock edge, and reads return combinationally from the current register contents. Two spare read/write words are provided as scratch storage.

The block has no state machine. Its state is the pending register, the enable register and the two scratch words. Each register moves on one transition per edge: it keeps its value, it is set by a request, or it is written or cleared by the bus.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, the pending, enable and both scratch registers read zero, the summary line is low and the index output is 0.
- R2: A request input that is high at a rising clock edge sets its pending bit. The bit stays set after the request drops, until software acknowledges it.
- R3: A bus write to byte offset 0x00 clears each pending bit whose data bit is 1 and leaves each bit whose data bit is 0 unchanged. Writing all ones clears every pending bit.
- R4: If a request is high in the same cycle as an acknowledge of its bit, the bit stays set.
- R5: The enable register at byte offset 0x08 is read/write. Clearing an enable bit removes that source from the gated view, and its pending bit is kept.
- R6: The gated view at byte offset 0x10 reads as pending AND enable, which is zero when no enabled source is pending. The summary line is high exactly when the gated view is nonzero.
- R7: The index output gives the bit position of the most significant 1 in the gated view, and is 0 when the gated view is zero.
- R8: A write to offset 0x10 changes no register.
- R9: Byte offsets 0x18 and 0x20 are independent 32-bit scratch words that read back what was last written.
- R10: Reads at any other offset return zero, and writes there change no register. While the bus select is low, the read data is zero and nothing is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 32 | Interrupt request lines, one per source |
| bus_sel_i | input | 1 | Bus access select |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the registers |
| irq_o | output | 1 | Summary interrupt to the processor |
| irq_idx_o | output | 5 | Index of the highest active gated source |

## Verification
The assertions check several things on every cycle. Every request seen at an edge lands in the pending bits. Acknowledged bits without a concurrent request are cleared, and pending bits never drop without an acknowledge. The enable and scratch words move only when written. The index always points at the top set bit of the gated view, and a write to the gated offset leaves that view unchanged. The bench covers what only ordered stimulus can show. It checks that masking and unmasking preserve pending state and that the index moves as higher sources are enabled or acknowledged. It checks that a held level reappears after an acknowledge, and that unmapped and deselected accesses read zero. A reference model is compared with all outputs on every clock throughout directed and random traffic.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam logic [7:0] OFF_PENDING = 8'h00;
    localparam logic [7:0] OFF_ENABLE  = 8'h08;
    localparam logic [7:0] OFF_GATED   = 8'h10;
    localparam logic [7:0] OFF_AUX0    = 8'h18;
    localparam logic [7:0] OFF_AUX1    = 8'h20;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PENDING,
        SEL_ENABLE,
        SEL_GATED,
        SEL_AUX0,
        SEL_AUX1
    } reg_sel_e;

endpackage

// File: rtl/irqc_pending.sv
module irqc_pending #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic [NUM_SRC-1:0] clr_mask_i,
    output logic [NUM_SRC-1:0] pending_o
);

    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] pend_d;

    // per-source next state: a request beats an acknowledge
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
        assign pend_d[k] = req_i[k] | (pend_q[k] & ~clr_mask_i[k]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign pending_o = pend_q;

    // R2
    req_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & $past(req_i)) == $past(req_i)));

    // R2
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(pend_q) & ~$past(clr_mask_i)) & ~pend_q) == '0));

    // R3
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & $past(clr_mask_i) & ~$past(req_i)) == '0));

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel_i,
    input  logic               bus_we_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [DATA_W-1:0]  bus_wdata_i,
    input  logic [NUM_SRC-1:0] pending_i,
    output logic [NUM_SRC-1:0] clr_mask_o,
    output logic [NUM_SRC-1:0] gated_o,
    output logic [DATA_W-1:0]  bus_rdata_o
);

    reg_sel_e           sel;
    logic               wr_en;
    logic [NUM_SRC-1:0] enable_q;
    logic [DATA_W-1:0]  aux0_q;
    logic [DATA_W-1:0]  aux1_q;

    always_comb begin
        if (bus_addr_i == ADDR_W'(OFF_PENDING)) begin
            sel = SEL_PENDING;
        end else if (bus_addr_i == ADDR_W'(OFF_ENABLE)) begin
            sel = SEL_ENABLE;
        end else if (bus_addr_i == ADDR_W'(OFF_GATED)) begin
            sel = SEL_GATED;
        end else if (bus_addr_i == ADDR_W'(OFF_AUX0)) begin
            sel = SEL_AUX0;
        end else if (bus_addr_i == ADDR_W'(OFF_AUX1)) begin
            sel = SEL_AUX1;
        end else begin
            sel = SEL_NONE;
        end
    end

    assign wr_en = bus_sel_i & bus_we_i;

    assign clr_mask_o = (wr_en && sel == SEL_PENDING) ? bus_wdata_i[NUM_SRC-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= '0;
            aux0_q   <= '0;
            aux1_q   <= '0;
        end else if (wr_en) begin
            if (sel == SEL_ENABLE) enable_q <= bus_wdata_i[NUM_SRC-1:0];
            if (sel == SEL_AUX0)   aux0_q   <= bus_wdata_i;
            if (sel == SEL_AUX1)   aux1_q   <= bus_wdata_i;
        end
    end

    assign gated_o = pending_i & enable_q;

    always_comb begin
        bus_rdata_o = '0;
        if (bus_sel_i) begin
            unique case (sel)
                SEL_PENDING: bus_rdata_o = DATA_W'(pending_i);
                SEL_ENABLE:  bus_rdata_o = DATA_W'(enable_q);
                SEL_GATED:   bus_rdata_o = DATA_W'(gated_o);
                SEL_AUX0:    bus_rdata_o = aux0_q;
                SEL_AUX1:    bus_rdata_o = aux1_q;
                SEL_NONE:    bus_rdata_o = '0;
                default:     bus_rdata_o = '0;
            endcase
        end
    end

    // R5
    enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel_i && bus_we_i && bus_addr_i == ADDR_W'(OFF_ENABLE)) |=> $stable(enable_q));

    // R9
    aux_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel_i && bus_we_i) |=> ($stable(aux0_q) && $stable(aux1_q)));

endmodule

// File: rtl/irqc_top_finder.sv
module irqc_top_finder #(
    parameter int NUM_SRC = 32,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] vec_i,
    output logic [IDX_W-1:0]   idx_o
);

    // later (higher) positions overwrite earlier ones
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (vec_i[i]) idx_o = IDX_W'(i);
        end
    end

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 8,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic               bus_sel_i,
    input  logic               bus_we_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [DATA_W-1:0]  bus_wdata_i,
    output logic [DATA_W-1:0]  bus_rdata_o,
    output logic               irq_o,
    output logic [IDX_W-1:0]   irq_idx_o
);

    logic [NUM_SRC-1:0] pending;
    logic [NUM_SRC-1:0] clr_mask;
    logic [NUM_SRC-1:0] gated;

    irqc_pending #(.NUM_SRC(NUM_SRC)) u_pending (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .clr_mask_i (clr_mask),
        .pending_o  (pending)
    );

    irqc_regs #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel_i   (bus_sel_i),
        .bus_we_i    (bus_we_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .pending_i   (pending),
        .clr_mask_o  (clr_mask),
        .gated_o     (gated),
        .bus_rdata_o (bus_rdata_o)
    );

    irqc_top_finder #(.NUM_SRC(NUM_SRC)) u_finder (
        .vec_i (gated),
        .idx_o (irq_idx_o)
    );

    assign irq_o = |gated;

    // R7
    idx_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gated != '0) |-> (gated[irq_idx_o] && ((gated >> irq_idx_o) == NUM_SRC'(1))));

    // R7
    idx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (irq_idx_o == '0));

    // R8
    gated_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel_i && bus_we_i && bus_addr_i == ADDR_W'(OFF_GATED) && req_i == '0)
        |=> $stable(gated));

endmodule

// File: tb/irq_ctrl_bench.sv
module irq_ctrl_bench;

    localparam int N  = 32;
    localparam int DW = 32;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic          sel = 1'b0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq;
    logic [4:0]    idx;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    irq_ctrl u_irq_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req),
        .bus_sel_i   (sel),
        .bus_we_i    (we),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq),
        .irq_idx_o   (idx)
    );

    // reference model
    logic [N-1:0]  m_pend;
    logic [N-1:0]  m_en;
    logic [DW-1:0] m_aux0;
    logic [DW-1:0] m_aux1;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pend <= '0;
            m_en   <= '0;
            m_aux0 <= '0;
            m_aux1 <= '0;
        end else begin
            if (sel && we && addr == 8'h00) m_pend <= (m_pend & ~wdata) | req;
            else                            m_pend <= m_pend | req;
            if (sel && we && addr == 8'h08) m_en   <= wdata;
            if (sel && we && addr == 8'h18) m_aux0 <= wdata;
            if (sel && we && addr == 8'h20) m_aux1 <= wdata;
        end
    end

    function automatic logic [DW-1:0] m_read(logic s, logic [AW-1:0] a);
        if (!s) return '0;
        case (a)
            8'h00:   return m_pend;
            8'h08:   return m_en;
            8'h10:   return m_pend & m_en;
            8'h18:   return m_aux0;
            8'h20:   return m_aux1;
            default: return '0;
        endcase
    endfunction

    function automatic int m_top(logic [N-1:0] v);
        int r = 0;
        for (int i = N - 1; i >= 0; i--) begin
            if (v[i]) begin
                r = i;
                break;
            end
        end
        return r;
    endfunction

    function automatic string rd_tag(logic [AW-1:0] a);
        case (a)
            8'h00:        return "R2 pending read";
            8'h08:        return "R5 enable read";
            8'h10:        return "R6 gated read";
            8'h18, 8'h20: return "R9 scratch read";
            default:      return "R10 unmapped read";
        endcase
    endfunction

    task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // compare outputs with the model on every clock
    always @(negedge clk) begin
        #1;
        chk("R6 summary line", DW'(irq), DW'(|(m_pend & m_en)));
        chk("R7 index", DW'(idx), DW'(m_top(m_pend & m_en)));
        chk(rd_tag(addr), rdata, m_read(sel, addr));
    end

    task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
        @(negedge clk);
        sel = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; we = 1'b0; wdata = '0;
        #1;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] v);
        @(negedge clk);
        sel = 1'b1; we = 1'b0; addr = a;
        #1;
        v = rdata;
    endtask

    task automatic pulse(logic [N-1:0] v);
        @(negedge clk);
        req = v;
        @(negedge clk);
        req = '0;
        #1;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [DW-1:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h00, v); chk("R1 pending after reset", v, 32'h0);
        rd(8'h08, v); chk("R1 enable after reset", v, 32'h0);
        rd(8'h18, v); chk("R1 scratch0 after reset", v, 32'h0);
        rd(8'h20, v); chk("R1 scratch1 after reset", v, 32'h0);
        chk("R1 irq after reset", DW'(irq), 32'h0);
        chk("R1 idx after reset", DW'(idx), 32'h0);

        // R2 pulse latched, R5 masked while disabled
        pulse(32'h0000_0008);
        rd(8'h00, v); chk("R2 pulse latched", v, 32'h0000_0008);
        rd(8'h10, v); chk("R5 masked source hidden", v, 32'h0);
        chk("R6 irq low while masked", DW'(irq), 32'h0);

        wr(8'h08, 32'h0000_0008);
        rd(8'h10, v); chk("R6 gated after enable", v, 32'h0000_0008);
        chk("R6 irq high", DW'(irq), 32'h1);
        chk("R7 idx 3", DW'(idx), 32'd3);

        pulse(32'h0002_0020);
        wr(8'h08, 32'hFFFF_FFFF);
        chk("R7 idx picks 17", DW'(idx), 32'd17);
        rd(8'h00, v); chk("R2 several latched", v, 32'h0002_0028);

        // R3 acknowledge
        wr(8'h00, 32'h0);
        rd(8'h00, v); chk("R3 zero write keeps bits", v, 32'h0002_0028);
        wr(8'h00, 32'h0000_0008);
        rd(8'h00, v); chk("R3 one bit cleared", v, 32'h0002_0020);

        // R5 mask keeps pending
        wr(8'h08, 32'hFFFD_FFFF);
        chk("R5 idx after masking 17", DW'(idx), 32'd5);
        rd(8'h00, v); chk("R5 masked bit still pending", v, 32'h0002_0020);
        wr(8'h08, 32'hFFFF_FFFF);
        chk("R5 idx after unmask", DW'(idx), 32'd17);

        // R4 request beats acknowledge
        @(negedge clk);
        req = 32'h0000_0020;
        sel = 1'b1; we = 1'b1; addr = 8'h00; wdata = 32'h0000_0020;
        @(negedge clk);
        req = '0; sel = 1'b0; we = 1'b0; wdata = '0;
        rd(8'h00, v); chk("R4 request wins over ack", v, 32'h0002_0020);
        wr(8'h00, 32'h0000_0020);
        rd(8'h00, v); chk("R3 ack after request gone", v, 32'h0002_0000);

        // R7 top bit
        pulse(32'h8000_0000);
        chk("R7 idx 31", DW'(idx), 32'd31);

        // R8 write to gated offset ignored
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, v); chk("R8 gated unchanged", v, 32'h8002_0000);
        rd(8'h00, v); chk("R8 pending unchanged", v, 32'h8002_0000);
        rd(8'h08, v); chk("R8 enable unchanged", v, 32'hFFFF_FFFF);

        // R3 clear all
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, v); chk("R3 all cleared", v, 32'h0);
        rd(8'h10, v); chk("R6 gated zero when idle", v, 32'h0);
        chk("R6 irq low when idle", DW'(irq), 32'h0);
        chk("R7 idx zero when idle", DW'(idx), 32'h0);

        // R9 scratch words
        wr(8'h18, 32'hA5A5_0001);
        wr(8'h20, 32'h1234_5678);
        rd(8'h18, v); chk("R9 scratch0", v, 32'hA5A5_0001);
        rd(8'h20, v); chk("R9 scratch1", v, 32'h1234_5678);

        // R10 unmapped and deselected
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h28, 32'hFFFF_FFFF);
        rd(8'h04, v); chk("R10 unmapped 0x04", v, 32'h0);
        rd(8'h28, v); chk("R10 unmapped 0x28", v, 32'h0);
        rd(8'h18, v); chk("R10 scratch0 untouched", v, 32'hA5A5_0001);
        rd(8'h00, v); chk("R10 pending untouched", v, 32'h0);
        @(negedge clk);
        sel = 1'b0; addr = 8'h18;
        #1;
        chk("R10 deselected read zero", rdata, 32'h0);

        // R2/R4 held level reappears after ack
        @(negedge clk);
        req = 32'h0000_0100;
        wr(8'h00, 32'h0000_0100);
        rd(8'h00, v); chk("R4 held level survives ack", v, 32'h0000_0100);
        @(negedge clk);
        req = '0;
        wr(8'h00, 32'h0000_0100);
        rd(8'h00, v); chk("R2 cleared after release", v, 32'h0);

        // random traffic, checked by the per-cycle model compare
        for (int n = 0; n < 600; n++) begin
            @(negedge clk);
            req = $urandom & $urandom & $urandom & $urandom;
            sel = ($urandom_range(0, 7) != 0);
            we  = ($urandom_range(0, 3) == 0);
            case ($urandom_range(0, 6))
                0: addr = 8'h00;
                1: addr = 8'h08;
                2: addr = 8'h10;
                3: addr = 8'h18;
                4: addr = 8'h20;
                5: addr = 8'h0C;
                default: addr = 8'h00;
            endcase
            wdata = $urandom;
        end
        @(negedge clk);
        req = '0; sel = 1'b0; we = 1'b0;
        repeat (3) @(negedge clk);
        #2;
        finish_run();
    end

endmodule